// File: doc/BRIEF.md
# Cross-Domain Reset Bridge

This block lets software on a bus clock reset a capture engine that runs on a different, possibly stopped, data clock. A write to the control register asks for a reset when its reset bit is written as zero. A bus reset also asks for one. The request is held as a level and passed into the data clock domain through a synchronizer. There it drives an active-high reset for the capture logic. An acknowledgement level comes back the same way, and the bus side ends the request only after that acknowledgement arrives.

While a request is outstanding, a status bit stays high. The register decoder returns this bit as the reset bit of the control register, so a reader can see that the capture side is still in reset. This matters most when the data clock has stopped and the round trip cannot finish. When the round trip does finish, the bus side emits a one-cycle completion pulse.

The two directions follow a four-phase level handshake. The request rises and the acknowledgement rises. Then the request falls and the acknowledgement falls. A new request never rises before the previous acknowledgement has returned low. A request asked for during that return-to-zero phase is remembered and launched afterwards.

Top module: `xdom_reset_bridge`

## Requirements
- R1: When no request is outstanding, a control write (`ctl_wr` high) whose bit 0 of `ctl_wdata` is 0 sets `rst_pending` in the bus cycle after the write.
- R2: A control write whose bit 0 is 1 has no effect. `rst_pending`, `done_pulse` and `capture_rst` stay low.
- R3: A bus reset (`bus_rst_n` low at a bus clock edge) raises a request. `rst_pending` is high in the cycle after that edge and through the reset. The request later completes like a written one.
- R4: Once raised, a request stays pending until its completion. Further control writes of either value during that time neither cancel it nor start a second one, so exactly one `done_pulse` follows.
- R5: The data-side reset `capture_rst` is asserted once the request has crossed into the data domain. It is still high in the cycle where `done_pulse` is high, and it falls only after the request has been withdrawn.
- R6: `done_pulse` is high for exactly one bus cycle. `rst_pending` is low in that same cycle, because completion takes priority and clears the request at the same edge.
- R7: Completion needs the acknowledgement to cross back. With the data clock stopped, `rst_pending` stays high and no `done_pulse` occurs. Restarting the clock lets the request complete.
- R8: A write with bit 0 low that arrives after completion but before the acknowledgement has returned low is remembered. `rst_pending` is high in the next cycle, and the new request is launched and completes with its own `done_pulse`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Bus reset, synchronous active-low; also a reset request source |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | DATA_W | Control register write data; bit RST_BIT (default 0) is the reset bit |
| rst_pending | output | 1 | Reset-in-progress status for register readback |
| done_pulse | output | 1 | One-cycle completion pulse on the bus clock |
| data_clk | input | 1 | Data (capture) clock |
| data_rst_n | input | 1 | Data domain reset, synchronous active-low |
| capture_rst | output | 1 | Active-high reset for the capture logic, data clock domain |

## Verification
A request state that goes wrong on the bus side shows up in `rst_pending` on the very next bus cycle. Examples are a request that is dropped, a stray request, or a write that is not ignored while pending. A broken handshake shows up later, about ten bus cycles on, at the end of the round trip. It appears as a missing, doubled or widened `done_pulse`, or as `capture_rst` already low when the pulse appears. A request started before the old acknowledgement has fallen can leave the data side seeing no falling edge. That stalls every later request, which the next completion count exposes.

// File: rtl/xrb_pkg.sv
// Shared types for the cross-domain reset bridge.
// Assumes: nothing beyond the standard language.
package xrb_pkg;

    // Bus-side request state: idle, request raised, or waiting for the
    // acknowledgement to return low after completion.
    typedef enum logic [1:0] {
        BR_IDLE   = 2'd0,
        BR_ACTIVE = 2'd1,
        BR_DRAIN  = 2'd2
    } br_state_e;

    localparam int unsigned XRB_MIN_SYNC = 2;

endpackage

// File: rtl/xrb_sync.sv
// Level synchronizer: a chain of STAGES flops clocked in the receiving
// domain. Assumes the input is a slow level held for several receiving
// clocks. rst_n is synchronous active-low and may be tied high where the
// chain must keep sampling through a local reset.
module xrb_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int unsigned N = (STAGES < xrb_pkg::XRB_MIN_SYNC) ? xrb_pkg::XRB_MIN_SYNC : STAGES;

    logic [N-1:0] chain;

    // Shift the asynchronous level through the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[N-2:0], d};
    end

    assign q = chain[N-1];
endmodule

// File: rtl/xrb_bus_ctl.sv
// Bus-side requester. It raises a request level on a bus reset or on a
// control write with the reset bit clear. It holds the request until the
// synchronized acknowledgement rises, then waits for that acknowledgement
// to fall before raising another. Requests arriving during the wait are
// remembered in a queued flag.
// Assumes: ack_sync is already synchronized to bus_clk. The bus reset is
// folded into the next-state logic as a request source rather than
// clearing the state. The acknowledgement edge register has no reset, so
// a bus reset can neither fake nor hide a rising edge.
module xrb_bus_ctl #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned RST_BIT = 0
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] ctl_wdata,
    input  logic              ack_sync,
    output logic              req_lvl,
    output logic              rst_pending,
    output logic              done_pulse
);
    import xrb_pkg::*;

    br_state_e st, nxt;
    logic queued, q_nxt;
    logic req_q, done_q, done_nxt;
    logic ack_d, ack_rise;
    logic wr_raise, start;
    logic unused_wdata;

    assign unused_wdata = ^ctl_wdata;
    assign wr_raise     = ctl_wr && !ctl_wdata[RST_BIT];
    assign start        = !bus_rst_n || wr_raise;
    assign ack_rise     = ack_sync && !ack_d;

    // Remember last acknowledgement level for edge detection.
    always_ff @(posedge bus_clk) begin
        ack_d <= ack_sync;
    end

    // Next state: completion first, then hold, then new requests.
    always_comb begin
        nxt      = st;
        q_nxt    = 1'b0;
        done_nxt = 1'b0;
        case (st)
            BR_IDLE: begin
                if (start) nxt = BR_ACTIVE;
            end
            BR_ACTIVE: begin
                if (ack_rise) begin
                    nxt      = BR_DRAIN;
                    done_nxt = bus_rst_n;
                    q_nxt    = !bus_rst_n;
                end
            end
            BR_DRAIN: begin
                if (!ack_sync) nxt = (queued || start) ? BR_ACTIVE : BR_IDLE;
                else           q_nxt = queued || start;
            end
            default: nxt = BR_ACTIVE;
        endcase
    end

    // State, queued flag, request level and completion pulse registers.
    always_ff @(posedge bus_clk) begin
        st     <= nxt;
        queued <= q_nxt;
        req_q  <= (nxt == BR_ACTIVE);
        if (!bus_rst_n) done_q <= 1'b0;
        else            done_q <= done_nxt;
    end

    assign req_lvl     = req_q;
    assign done_pulse  = done_q;
    assign rst_pending = (st == BR_ACTIVE) || queued;

    // R1: an idle block accepts a clear-bit write as a new request.
    p_raise_r1: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (st == BR_IDLE && ctl_wr && !ctl_wdata[RST_BIT]) |=> rst_pending);
    // R2: a set-bit write leaves an idle block idle.
    p_ignore_r2: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (st == BR_IDLE && ctl_wr && ctl_wdata[RST_BIT]) |=> !rst_pending);
    // R4: a raised request holds until the acknowledgement edge.
    p_hold_r4: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (st == BR_ACTIVE && !ack_rise) |=> (st == BR_ACTIVE && req_lvl));
    // R6: completion is one cycle wide and clears the status.
    p_done_width_r6: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        done_pulse |=> !done_pulse);
    p_done_clear_r6: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        done_pulse |-> !rst_pending);
    // R8: four-phase order, request rises only with acknowledgement low.
    p_hs_order_r8: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        $rose(req_lvl) |-> !ack_sync);
endmodule

// File: rtl/xrb_data_ctl.sv
// Data-side responder. It asserts the capture reset one data clock after
// the synchronized request is seen high and keeps it until the request is
// seen low. It returns an acknowledgement that trails the capture reset by
// one clock, so the reset has been applied for at least one data clock
// before the bus side can complete.
// Assumes: req_sync is already synchronized to data_clk.
module xrb_data_ctl (
    input  logic data_clk,
    input  logic data_rst_n,
    input  logic req_sync,
    output logic capture_rst,
    output logic ack_lvl
);
    logic rst_q, ack_q;

    // Follow the request with the reset, then the reset with the ack.
    always_ff @(posedge data_clk) begin
        if (!data_rst_n) begin
            rst_q <= 1'b0;
            ack_q <= 1'b0;
        end else begin
            rst_q <= req_sync;
            ack_q <= rst_q;
        end
    end

    assign capture_rst = rst_q;
    assign ack_lvl     = ack_q;

    // R5: reset stays up while the request is still seen high.
    p_rst_hold_r5: assert property (@(posedge data_clk) disable iff (!data_rst_n)
        (capture_rst && req_sync) |=> capture_rst);
    // R5: acknowledgement rises only after the reset was applied.
    p_ack_after_rst_r5: assert property (@(posedge data_clk) disable iff (!data_rst_n)
        $rose(ack_lvl) |-> $past(capture_rst));
endmodule

// File: rtl/xdom_reset_bridge.sv
// Cross-domain reset bridge top. It carries a reset request from the bus
// clock to the data clock and back with a four-phase level handshake. It
// drives the capture reset in the data domain and reports pending status
// and completion on the bus side.
// Assumes: the two clocks are unrelated. The acknowledgement synchronizer
// is never reset, so a bus reset cannot lose an acknowledgement in flight.
module xdom_reset_bridge #(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned RST_BIT     = 0,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] ctl_wdata,
    output logic              rst_pending,
    output logic              done_pulse,
    input  logic              data_clk,
    input  logic              data_rst_n,
    output logic              capture_rst
);
    logic req_lvl, req_sync, ack_lvl, ack_sync;

    xrb_bus_ctl #(.DATA_W(DATA_W), .RST_BIT(RST_BIT)) u_bus (
        .bus_clk     (bus_clk),
        .bus_rst_n   (bus_rst_n),
        .ctl_wr      (ctl_wr),
        .ctl_wdata   (ctl_wdata),
        .ack_sync    (ack_sync),
        .req_lvl     (req_lvl),
        .rst_pending (rst_pending),
        .done_pulse  (done_pulse)
    );

    xrb_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (data_clk),
        .rst_n (data_rst_n),
        .d     (req_lvl),
        .q     (req_sync)
    );

    xrb_data_ctl u_data (
        .data_clk    (data_clk),
        .data_rst_n  (data_rst_n),
        .req_sync    (req_sync),
        .capture_rst (capture_rst),
        .ack_lvl     (ack_lvl)
    );

    xrb_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (bus_clk),
        .rst_n (1'b1),
        .d     (ack_lvl),
        .q     (ack_sync)
    );
endmodule

// File: tb/xdom_reset_bridge_bench.sv
module xdom_reset_bridge_bench;
    localparam int CLK_PERIOD  = 10;
    localparam int DATA_PERIOD = 14;
    localparam int DW          = 32;

    logic          bus_clk = 1'b0;
    logic          data_clk = 1'b0;
    logic          data_clk_en = 1'b1;
    logic          bus_rst_n = 1'b0;
    logic          data_rst_n = 1'b0;
    logic          ctl_wr = 1'b0;
    logic [DW-1:0] ctl_wdata = '0;
    logic          rst_pending, done_pulse, capture_rst;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    xdom_reset_bridge #(.DATA_W(DW)) u_xdom_reset_bridge (
        .bus_clk     (bus_clk),
        .bus_rst_n   (bus_rst_n),
        .ctl_wr      (ctl_wr),
        .ctl_wdata   (ctl_wdata),
        .rst_pending (rst_pending),
        .done_pulse  (done_pulse),
        .data_clk    (data_clk),
        .data_rst_n  (data_rst_n),
        .capture_rst (capture_rst)
    );

    always #(CLK_PERIOD/2) bus_clk = ~bus_clk;
    always begin
        #(DATA_PERIOD/2);
        if (data_clk_en) data_clk = ~data_clk;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Expected: a write raises a request only when bit 0 is clear.
    function automatic bit exp_raise(input logic [DW-1:0] w);
        return !w[0];
    endfunction

    task automatic do_write(input logic [DW-1:0] w);
        ctl_wdata = w;
        ctl_wr    = 1'b1;
        @(negedge bus_clk);
        ctl_wr    = 1'b0;
    endtask

    // Run n bus cycles; count completions, check R5/R6 at each pulse.
    task automatic run_cycles(input int n, output int nd, output bit cap);
        bit prev = 1'b0;
        nd  = 0;
        cap = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge bus_clk);
            if (capture_rst) cap = 1'b1;
            if (done_pulse) begin
                nd++;
                chk(capture_rst == 1'b1, "R5 capture reset held at completion", int'(capture_rst), 1);
                chk(rst_pending == 1'b0, "R6 status clear at completion", int'(rst_pending), 0);
                chk(!prev, "R6 pulse width one cycle", 2, 1);
            end
            prev = done_pulse;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int nd;
        bit cap;
        logic [DW-1:0] w;
        void'($urandom(32'd4711));

        // R3: reset state, request raised by bus reset.
        repeat (6) @(negedge bus_clk);
        chk(rst_pending == 1'b1, "R3 pending during bus reset", int'(rst_pending), 1);
        chk(capture_rst == 1'b0, "R3 capture reset low in data reset", int'(capture_rst), 0);
        chk(done_pulse == 1'b0, "R3 no completion in reset", int'(done_pulse), 0);
        data_rst_n = 1'b1;
        repeat (2) @(negedge bus_clk);
        bus_rst_n = 1'b1;
        run_cycles(60, nd, cap);
        chk(nd == 1, "R3 reset request completes once", nd, 1);
        chk(cap, "R5 capture reset seen", int'(cap), 1);
        chk(rst_pending == 1'b0, "R3 idle after completion", int'(rst_pending), 0);
        chk(capture_rst == 1'b0, "R5 capture reset released", int'(capture_rst), 0);

        // R2: set reset bit is ignored.
        do_write(32'h0000_0001);
        chk(rst_pending == 1'b0, "R2 set bit no status", int'(rst_pending), 0);
        run_cycles(30, nd, cap);
        chk(nd == 0, "R2 set bit no completion", nd, 0);
        chk(!cap, "R2 set bit no capture reset", int'(cap), 0);

        // R1: clear reset bit raises and completes.
        do_write(32'hFFFF_FFFE);
        chk(rst_pending == 1'b1, "R1 status after write", int'(rst_pending), 1);
        run_cycles(60, nd, cap);
        chk(nd == 1, "R1 one completion", nd, 1);
        chk(cap, "R5 capture reset seen", int'(cap), 1);

        // R4: writes while pending neither cancel nor repeat.
        do_write(32'h0);
        do_write(32'h0000_0010);
        chk(rst_pending == 1'b1, "R4 second write keeps pending", int'(rst_pending), 1);
        do_write(32'h0000_0001);
        chk(rst_pending == 1'b1, "R4 set-bit write does not cancel", int'(rst_pending), 1);
        run_cycles(80, nd, cap);
        chk(nd == 1, "R4 exactly one completion", nd, 1);

        // R8: request during acknowledgement return is queued.
        do_write(32'h0);
        for (int i = 0; i < 60; i++) begin
            if (done_pulse) break;
            @(negedge bus_clk);
        end
        chk(done_pulse == 1'b1, "R8 first completion reached", int'(done_pulse), 1);
        do_write(32'h0000_0100);
        chk(rst_pending == 1'b1, "R8 queued request visible", int'(rst_pending), 1);
        run_cycles(120, nd, cap);
        chk(nd == 1, "R8 queued request completes", nd, 1);
        chk(rst_pending == 1'b0, "R8 idle afterwards", int'(rst_pending), 0);

        // R7: stopped data clock keeps request pending.
        data_clk_en = 1'b0;
        do_write(32'h0);
        run_cycles(60, nd, cap);
        chk(nd == 0, "R7 no completion without data clock", nd, 0);
        chk(rst_pending == 1'b1, "R7 still pending", int'(rst_pending), 1);
        data_clk_en = 1'b1;
        run_cycles(80, nd, cap);
        chk(nd == 1, "R7 completes after clock restart", nd, 1);

        // R3: short bus reset pulse from idle.
        bus_rst_n = 1'b0;
        repeat (2) @(negedge bus_clk);
        bus_rst_n = 1'b1;
        chk(rst_pending == 1'b1, "R3 short reset raises request", int'(rst_pending), 1);
        run_cycles(60, nd, cap);
        chk(nd == 1, "R3 short reset completes", nd, 1);

        // R1/R2 random words.
        for (int k = 0; k < 16; k++) begin
            w = $urandom;
            do_write(w);
            chk(rst_pending == exp_raise(w), "R1 R2 random status", int'(rst_pending), int'(exp_raise(w)));
            run_cycles(60, nd, cap);
            chk(nd == int'(exp_raise(w)), "R1 R2 random completions", nd, int'(exp_raise(w)));
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule